// File: doc/BRIEF.md
# USB OUT Endpoint Data Toggle Checker

This block sits in the receive path of a high-speed USB device controller. It keeps one DATA0/DATA1 toggle bit for each OUT endpoint. For every data packet that arrives, it decides whether the packet is new data or a repeat of one already taken. New data is accepted and reported to software. A repeat is dropped without a report. Every packet with a good CRC gets a handshake, ACK or NYET, so that the host moves on. This includes a dropped repeat.

Each endpoint has a configuration bit that turns the sequence check off. With the bit set, the endpoint takes every packet. A toggle-clear pulse for an endpoint sets its state back to DATA0. Software uses it after configuration or after a halt is cleared. The decision is registered and is valid one cycle after the packet-end strobe. The toggle bit of an accepted packet changes at the same clock edge.

Top module: `usb_out_toggle_chk`

## Requirements
- R1: During reset and on the first cycle after it, `toggle_state` is all zero, so every endpoint expects DATA0. `rsp_valid` is 0 at the same time.
- R2: When `toggle_inhibit[ep]` is 1, a good-CRC packet to `ep` is accepted whatever `pkt_pid_data1` is and whatever the endpoint's stored toggle is.
- R3: When `toggle_inhibit[ep]` is 0, a good-CRC packet is accepted only when `pkt_pid_data1` equals `toggle_state[ep]`. On `pkt_pid_data1`, 1 means DATA1 and 0 means DATA0. An accepted packet sets both `rsp_accept` and `rsp_report`.
- R4: A good-CRC packet whose PID does not match, with inhibit 0, is discarded. It gives `rsp_valid`=1 with `rsp_accept`=0 and `rsp_report`=0, and the endpoint's toggle keeps its value.
- R5: A good-CRC packet produces `rsp_valid`=1 exactly one cycle after the cycle in which `pkt_done` was high. `rsp_hs_nyet` is 1 (NYET) when `buf_not_ready[ep]` was 1 in that cycle and 0 (ACK) otherwise. This rule is the same for accepted and discarded packets.
- R6: An accepted packet inverts `toggle_state[ep]`. The new value is visible in the same cycle as its response.
- R7: A packet changes no toggle bit except the one of its own endpoint.
- R8: A 1 on `toggle_clear[i]` sets `toggle_state[i]` to 0 at the next edge. It overrides the inversion from a packet to the same endpoint in the same cycle. The handshake of that packet is still given.
- R9: A packet with `pkt_crc_ok`=0, or a cycle with no `pkt_done`, gives `rsp_valid`=0 on the next cycle and leaves every toggle unchanged. While `rsp_valid` is 0, the signals `rsp_accept`, `rsp_report` and `rsp_hs_nyet` are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pkt_done | input | 1 | One-cycle strobe at the end of a received data packet |
| pkt_crc_ok | input | 1 | The packet ending this cycle had a good CRC |
| pkt_ep | input | 2 | Endpoint index of the packet |
| pkt_pid_data1 | input | 1 | Data PID of the packet: 1 = DATA1, 0 = DATA0 |
| toggle_inhibit | input | 4 | Per-endpoint bit that turns the sequence check off |
| buf_not_ready | input | 4 | Per-endpoint bit that selects NYET instead of ACK |
| toggle_clear | input | 4 | Per-endpoint pulse that resets the toggle to DATA0 |
| rsp_valid | output | 1 | The response fields are valid this cycle |
| rsp_accept | output | 1 | 1 = the packet is kept, 0 = it is discarded |
| rsp_report | output | 1 | Strobe that reports a completed packet to software |
| rsp_hs_nyet | output | 1 | Handshake select: 1 = NYET, 0 = ACK |
| toggle_state | output | 4 | Current toggle per endpoint: 1 = DATA1 expected next |

## Verification
The properties assume `pkt_done` is a single-cycle pulse. They also assume `pkt_ep`, `pkt_pid_data1` and the per-endpoint vectors are stable in the cycle of that pulse. The toggle properties assume no `toggle_clear` bit is high in the cycle they examine, so each one checks packet effects only when no clear is mixed in. The bench drives every input at the falling edge and holds it for one full cycle. It pulses `pkt_done` for exactly one cycle, and it raises `toggle_clear` only in dedicated steps, one of which deliberately collides with a packet to test the override.

// File: rtl/usb_tog_pkg.sv
// Package: shared types for the OUT-endpoint toggle checker.
// Assumes: included first in compile order.
package usb_tog_pkg;

    // Handshake token chosen for a good-CRC packet.
    typedef enum logic {
        HS_ACK  = 1'b0,
        HS_NYET = 1'b1
    } hs_e;

    // Registered response to one packet.
    typedef struct packed {
        logic valid;
        logic accept;
        logic report;
        hs_e  hs;
    } rsp_t;

    localparam rsp_t RSP_IDLE = '{valid: 1'b0, accept: 1'b0, report: 1'b0, hs: HS_ACK};

endpackage

// File: rtl/usb_tog_bank.sv
// Module: per-endpoint toggle register bank.
// Each endpoint owns one bit. A clear pulse forces the bit to DATA0 (0)
// and wins over an inversion requested in the same cycle.
// Assumes: flip_idx < NUM_EP whenever flip_en is high.
module usb_tog_bank #(
    parameter int NUM_EP = 4,
    parameter int EP_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] clr,
    input  logic              flip_en,
    input  logic [EP_W-1:0]   flip_idx,
    output logic [NUM_EP-1:0] tog
);

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic hit;

        // Purpose: decode whether this endpoint is the one to invert.
        always_comb begin
            hit = flip_en && (flip_idx == EP_W'(i));
        end

        // Purpose: hold the endpoint toggle; reset and clear give DATA0.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tog[i] <= 1'b0;
            end else if (clr[i]) begin
                tog[i] <= 1'b0;
            end else if (hit) begin
                tog[i] <= ~tog[i];
            end
        end
    end

endmodule

// File: rtl/usb_tog_judge.sv
// Module: combinational packet judge.
// Compares the data PID with the stored toggle, unless inhibit is set,
// and picks the handshake from the endpoint's buffer-ready flag.
// Assumes: inputs are stable in the cycle of pkt_done.
module usb_tog_judge #(
    parameter int NUM_EP = 4,
    parameter int EP_W   = 2
) (
    input  logic                    pkt_done,
    input  logic                    pkt_crc_ok,
    input  logic [EP_W-1:0]         pkt_ep,
    input  logic                    pkt_pid_data1,
    input  logic [NUM_EP-1:0]       tog,
    input  logic [NUM_EP-1:0]       inhibit,
    input  logic [NUM_EP-1:0]       not_ready,
    output usb_tog_pkg::rsp_t       rsp_nxt,
    output logic                    flip_en
);
    import usb_tog_pkg::*;

    logic good;
    logic seq_ok;

    // Purpose: qualify the packet and test its sequence bit.
    always_comb begin
        good   = pkt_done && pkt_crc_ok;
        seq_ok = inhibit[pkt_ep] || (pkt_pid_data1 == tog[pkt_ep]);
    end

    // Purpose: build the response and the toggle-inversion request.
    always_comb begin
        rsp_nxt = RSP_IDLE;
        flip_en = 1'b0;
        if (good) begin
            rsp_nxt.valid  = 1'b1;
            rsp_nxt.accept = seq_ok;
            rsp_nxt.report = seq_ok;
            rsp_nxt.hs     = not_ready[pkt_ep] ? HS_NYET : HS_ACK;
            flip_en        = seq_ok;
        end
    end

endmodule

// File: rtl/usb_tog_rsp.sv
// Module: response output register.
// Registers the judge's decision so that the outputs are stable for a
// full cycle after the packet strobe.
// Assumes: nothing beyond a free-running clock.
module usb_tog_rsp (
    input  logic              clk,
    input  logic              rst_n,
    input  usb_tog_pkg::rsp_t rsp_nxt,
    output usb_tog_pkg::rsp_t rsp_q
);
    import usb_tog_pkg::*;

    // Purpose: capture the response; idle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= RSP_IDLE;
        end else begin
            rsp_q <= rsp_nxt;
        end
    end

endmodule

// File: rtl/usb_out_toggle_chk.sv
// Module: top of the OUT-endpoint data toggle checker.
// Joins the judge, the toggle bank and the response register. The
// response is valid one cycle after pkt_done, and the toggle state is
// updated at that same edge.
// Assumes: NUM_EP >= 2; pkt_done is a single-cycle pulse.
module usb_out_toggle_chk #(
    parameter int NUM_EP = 4,
    localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_done,
    input  logic              pkt_crc_ok,
    input  logic [EP_W-1:0]   pkt_ep,
    input  logic              pkt_pid_data1,
    input  logic [NUM_EP-1:0] toggle_inhibit,
    input  logic [NUM_EP-1:0] buf_not_ready,
    input  logic [NUM_EP-1:0] toggle_clear,
    output logic              rsp_valid,
    output logic              rsp_accept,
    output logic              rsp_report,
    output logic              rsp_hs_nyet,
    output logic [NUM_EP-1:0] toggle_state
);
    import usb_tog_pkg::*;

    rsp_t              rsp_nxt;
    rsp_t              rsp_q;
    logic              flip_en;
    logic [NUM_EP-1:0] tog;

    usb_tog_judge #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_judge (
        .pkt_done      (pkt_done),
        .pkt_crc_ok    (pkt_crc_ok),
        .pkt_ep        (pkt_ep),
        .pkt_pid_data1 (pkt_pid_data1),
        .tog           (tog),
        .inhibit       (toggle_inhibit),
        .not_ready     (buf_not_ready),
        .rsp_nxt       (rsp_nxt),
        .flip_en       (flip_en)
    );

    usb_tog_bank #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (toggle_clear),
        .flip_en  (flip_en),
        .flip_idx (pkt_ep),
        .tog      (tog)
    );

    usb_tog_rsp u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rsp_nxt (rsp_nxt),
        .rsp_q   (rsp_q)
    );

    // Purpose: unpack the registered response onto the ports.
    always_comb begin
        rsp_valid    = rsp_q.valid;
        rsp_accept   = rsp_q.accept;
        rsp_report   = rsp_q.report;
        rsp_hs_nyet  = (rsp_q.hs == HS_NYET);
        toggle_state = tog;
    end

endmodule

// File: rtl/usb_out_toggle_chk_sva.sv
// Module: property checker for usb_out_toggle_chk, attached by bind.
// Assumes: single-cycle pkt_done pulses; toggle properties are examined
// only in cycles with no toggle_clear bit high.
module usb_out_toggle_chk_sva #(
    parameter int NUM_EP = 4,
    parameter int EP_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_done,
    input logic              pkt_crc_ok,
    input logic [EP_W-1:0]   pkt_ep,
    input logic              pkt_pid_data1,
    input logic [NUM_EP-1:0] toggle_inhibit,
    input logic [NUM_EP-1:0] buf_not_ready,
    input logic [NUM_EP-1:0] toggle_clear,
    input logic              rsp_valid,
    input logic              rsp_accept,
    input logic              rsp_report,
    input logic              rsp_hs_nyet,
    input logic [NUM_EP-1:0] toggle_state
);

    // R5
    rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(pkt_done && pkt_crc_ok));

    // R5
    hs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hs_nyet == $past(buf_not_ready[pkt_ep])));

    // R3
    report_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_report == rsp_accept);

    // R9
    idle_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_accept && !rsp_hs_nyet));

    // R9
    bad_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && !pkt_crc_ok && toggle_clear == '0) |=> (!rsp_valid && $stable(toggle_state)));

    // R4
    dup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && pkt_crc_ok && toggle_clear == '0 && !toggle_inhibit[pkt_ep]
         && pkt_pid_data1 != toggle_state[pkt_ep])
        |=> ($stable(toggle_state) && rsp_valid && !rsp_accept));

    // R6 R7
    flip_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && pkt_crc_ok && toggle_clear == '0
         && (toggle_inhibit[pkt_ep] || pkt_pid_data1 == toggle_state[pkt_ep]))
        |=> ((toggle_state ^ $past(toggle_state)) == (NUM_EP'(1) << $past(pkt_ep))));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|toggle_clear) |=> ((toggle_state & $past(toggle_clear)) == '0));

endmodule

bind usb_out_toggle_chk usb_out_toggle_chk_sva #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .pkt_done       (pkt_done),
    .pkt_crc_ok     (pkt_crc_ok),
    .pkt_ep         (pkt_ep),
    .pkt_pid_data1  (pkt_pid_data1),
    .toggle_inhibit (toggle_inhibit),
    .buf_not_ready  (buf_not_ready),
    .toggle_clear   (toggle_clear),
    .rsp_valid      (rsp_valid),
    .rsp_accept     (rsp_accept),
    .rsp_report     (rsp_report),
    .rsp_hs_nyet    (rsp_hs_nyet),
    .toggle_state   (toggle_state)
);

// File: tb/usb_out_toggle_chk_bench.sv
// Bench: walks a vector table, then runs directed reset and clear tests.
module usb_out_toggle_chk_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_done = 1'b0;
    logic       pkt_crc_ok = 1'b0;
    logic [1:0] pkt_ep = '0;
    logic       pkt_pid_data1 = 1'b0;
    logic [3:0] toggle_inhibit = '0;
    logic [3:0] buf_not_ready = '0;
    logic [3:0] toggle_clear = '0;
    logic       rsp_valid, rsp_accept, rsp_report, rsp_hs_nyet;
    logic [3:0] toggle_state;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    usb_out_toggle_chk #(.NUM_EP(4)) u_usb_out_toggle_chk (
        .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .pkt_crc_ok(pkt_crc_ok),
        .pkt_ep(pkt_ep), .pkt_pid_data1(pkt_pid_data1),
        .toggle_inhibit(toggle_inhibit), .buf_not_ready(buf_not_ready),
        .toggle_clear(toggle_clear), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
        .rsp_report(rsp_report), .rsp_hs_nyet(rsp_hs_nyet), .toggle_state(toggle_state)
    );

    typedef struct packed {
        logic [1:0] ep;
        logic       pid;
        logic       crc;
        logic [3:0] inh;
        logic [3:0] nrdy;
        logic       e_val;
        logic       e_acc;
        logic       e_nyet;
        logic [3:0] e_tog;
    } vec_t;

    // ep pid crc inh nrdy | valid accept nyet toggle-after
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b1, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0001}, // R3 R6 match
        '{2'd0, 1'b0, 1'b1, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 4'b0001}, // R4 duplicate, ACK
        '{2'd0, 1'b1, 1'b1, 4'b0000, 4'b0001, 1'b1, 1'b1, 1'b1, 4'b0000}, // R5 NYET on accept
        '{2'd1, 1'b1, 1'b1, 4'b0000, 4'b0010, 1'b1, 1'b0, 1'b1, 4'b0000}, // R4 R5 NYET on discard
        '{2'd1, 1'b0, 1'b0, 4'b0000, 4'b0010, 1'b0, 1'b0, 1'b0, 4'b0000}, // R9 bad CRC
        '{2'd1, 1'b0, 1'b1, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0010}, // R7 ep1 only
        '{2'd2, 1'b1, 1'b1, 4'b0100, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0110}, // R2 inhibit, PID off
        '{2'd2, 1'b0, 1'b1, 4'b0100, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0010}, // R2 inhibit, PID off again
        '{2'd3, 1'b1, 1'b1, 4'b0100, 4'b0000, 1'b1, 1'b0, 1'b0, 4'b0010}, // R4 inhibit of ep2 not ep3
        '{2'd3, 1'b0, 1'b1, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b1010}, // R3 R7
        '{2'd2, 1'b0, 1'b1, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b1110}  // R3 checking back on
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one packet at a falling edge; sample one cycle later.
    task automatic send(input logic [1:0] ep, input logic pid, input logic crc,
                        input logic [3:0] clr);
        @(negedge clk);
        pkt_done = 1'b1; pkt_crc_ok = crc; pkt_ep = ep; pkt_pid_data1 = pid;
        toggle_clear = clr;
        @(negedge clk);
        pkt_done = 1'b0; pkt_crc_ok = 1'b0; toggle_clear = '0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 toggle in reset", toggle_state, 4'b0000);
        chk("R1 valid in reset", rsp_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 toggle after reset", toggle_state, 4'b0000);
        chk("R1 valid after reset", rsp_valid, 1'b0);

        for (int i = 0; i < NV; i++) begin
            toggle_inhibit = VECS[i].inh;
            buf_not_ready  = VECS[i].nrdy;
            send(VECS[i].ep, VECS[i].pid, VECS[i].crc, 4'b0000);
            chk($sformatf("R5 valid v%0d", i), rsp_valid, VECS[i].e_val);
            chk($sformatf("R3 R4 accept v%0d", i), rsp_accept, VECS[i].e_acc);
            chk($sformatf("R3 R4 report v%0d", i), rsp_report, VECS[i].e_acc);
            chk($sformatf("R5 nyet v%0d", i), rsp_hs_nyet, VECS[i].e_nyet);
            chk($sformatf("R6 R7 toggle v%0d", i), toggle_state, VECS[i].e_tog);
        end
        toggle_inhibit = '0;
        buf_not_ready  = '0;

        // R9: idle cycle after a response gives no response.
        @(negedge clk);
        chk("R9 idle valid", rsp_valid, 1'b0);
        chk("R9 idle accept", rsp_accept, 1'b0);
        chk("R9 idle toggle", toggle_state, 4'b1110);

        // R8: clear pulse alone on ep1 and ep2.
        @(negedge clk);
        toggle_clear = 4'b0110;
        @(negedge clk);
        toggle_clear = '0;
        chk("R8 clear", toggle_state, 4'b1000);

        // R8: clear on ep3 collides with a matching packet to ep3.
        buf_not_ready = 4'b1000;
        send(2'd3, 1'b1, 1'b1, 4'b1000);
        chk("R8 collide valid", rsp_valid, 1'b1);
        chk("R8 collide nyet", rsp_hs_nyet, 1'b1);
        chk("R8 collide toggle", toggle_state, 4'b0000);
        buf_not_ready = '0;

        // R1: reset in mid-run returns toggles to DATA0.
        send(2'd0, 1'b0, 1'b1, 4'b0000);
        chk("R6 before reset", toggle_state, 4'b0001);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset toggle", toggle_state, 4'b0000);
        chk("R1 mid-run reset valid", rsp_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule